// File: doc/BRIEF.md
# Flash Program/Erase Status Flag Generator

This block produces the read data of a parallel NOR flash while an internal program or erase operation is running. When a write command has been accepted, reads no longer return array contents. The top three bits of the read byte carry status flags instead. The top bit is a polling flag whose value depends on the operation type. The bit below it flips on every read access. The third bit reports that the internal pulse count has run out. The low bits keep showing the stored byte and do not change while the operation runs. When the operation ends, reads return true data again.

The block models one addressed byte location. A program operation can only clear bits: the result is the old content ANDed with the written byte. An erase sets every bit to 1. A program or erase aimed at a protected sector keeps the flags running for a fixed number of clock cycles, set by a parameter. After that the block goes back to read mode and the data is unchanged. The command decoder asserts `cmd_valid` on the cycle of the final write pulse of a command. Status is valid from the next cycle on.

Top module: `flash_status_gen`

## Requirements
- R1: After reset the block is idle and `rd_data` reads 8'hFF, which is the erased byte.
- R2: During an unprotected program, `rd_data[7]` reads the inverse of bit 7 of the programmed byte. This holds from the cycle after `cmd_valid` until completion.
- R3: A program completes in the cycle after `timer_done`. From then on the stored byte equals the old byte ANDed with the programmed byte, and `rd_data` returns that byte.
- R4: During an unprotected erase, `rd_data[7]` reads 0. The erase completes in the cycle after `timer_done`, and `rd_data` then reads 8'hFF.
- R5: `rd_data[6]` is 0 in the first cycle after a command is accepted. It inverts after every cycle in which `rd_strobe` is high, as long as the operation runs and has not failed. When the block is idle, `rd_strobe` leaves `rd_data` unchanged.
- R6: While any operation is active, `rd_data[4:0]` shows bits 4..0 of the byte stored before that operation, and they do not change.
- R7: A program with `sect_prot` high shows status for exactly `PROT_PGM_CYC` cycles and ignores `timer_done` during that time. It then returns to reads with the stored byte unchanged.
- R8: An erase with `sect_prot` high shows status for exactly `PROT_ERS_CYC` cycles and ignores `timer_done` during that time. It then returns to reads with the stored byte unchanged.
- R9: `pulse_over` during an unprotected operation puts the block in a failed state, and it takes priority over `timer_done` in the same cycle. In the failed state `rd_data[5]` reads 1 and bit 7 keeps its polling value. Bit 6 stops inverting, `timer_done` is ignored and the stored byte is kept. A new `cmd_valid` leaves the failed state. In every other active state `rd_data[5]` reads 0.
- R10: `cmd_valid` is ignored while a program or erase is in progress, whether protected or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Program or erase command accepted (final write pulse) |
| cmd_erase | input | 1 | 1 = erase, 0 = program |
| cmd_data | input | DW | Byte being programmed |
| sect_prot | input | 1 | Target sector(s) protected |
| timer_done | input | 1 | Internal operation timer finished |
| pulse_over | input | 1 | Internal pulse count exceeded |
| rd_strobe | input | 1 | One read access (chip-enable or output-enable edge) |
| rd_data | output | DW | Read data: status while active, stored byte when idle |

## Verification
Every program byte value from 0 to 255 is applied after an erase. This separates inverted polling from true polling on both values of bit 7, and shows whether the result comes from the AND merge or from plain overwrite. A second program of a bit-shuffled pattern follows without an erase, which catches a merge that loses earlier zeros. The protected windows are walked cycle by cycle, with `timer_done` held high and the stored byte chosen so that status and data differ in the top bits, which pins down the window length to the cycle. Failure is driven alone and together with `timer_done` to check its priority, its sticky flag and the frozen toggle.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_PROT,
        ST_FAIL
    } op_state_e;

    function automatic int unsigned fsg_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fsg_op_ctrl.sv
module fsg_op_ctrl
    import fsg_pkg::*;
#(
    parameter int unsigned DW           = 8,
    parameter int unsigned PROT_PGM_CYC = 8,
    parameter int unsigned PROT_ERS_CYC = 400
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_erase,
    input  logic [DW-1:0] cmd_data,
    input  logic          sect_prot,
    input  logic          timer_done,
    input  logic          pulse_over,
    output logic          start_o,
    output logic          busy_o,
    output logic          run_o,
    output logic          failed_o,
    output logic          poll_o,
    output logic [DW-1:0] store_o
);

    localparam int unsigned MAXW = fsg_max(PROT_PGM_CYC, PROT_ERS_CYC);
    localparam int unsigned CW   = $clog2(MAXW + 1);

    typedef struct packed {
        op_state_e     st;
        logic          is_erase;
        logic [DW-1:0] wdata;
        logic [DW-1:0] store;
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic accept;

    always_comb begin
        ctl_d  = ctl_q;
        accept = cmd_valid && (ctl_q.st == ST_IDLE || ctl_q.st == ST_FAIL);
        case (ctl_q.st)
            ST_IDLE, ST_FAIL: begin
                if (accept) begin
                    ctl_d.is_erase = cmd_erase;
                    ctl_d.wdata    = cmd_data;
                    if (sect_prot) begin
                        ctl_d.st  = ST_PROT;
                        ctl_d.cnt = cmd_erase ? CW'(PROT_ERS_CYC - 1) : CW'(PROT_PGM_CYC - 1);
                    end else begin
                        ctl_d.st = cmd_erase ? ST_ERASE : ST_PROG;
                    end
                end
            end
            ST_PROG: begin
                if (pulse_over) begin
                    ctl_d.st = ST_FAIL;
                end else if (timer_done) begin
                    ctl_d.store = ctl_q.store & ctl_q.wdata;
                    ctl_d.st    = ST_IDLE;
                end
            end
            ST_ERASE: begin
                if (pulse_over) begin
                    ctl_d.st = ST_FAIL;
                end else if (timer_done) begin
                    ctl_d.store = '1;
                    ctl_d.st    = ST_IDLE;
                end
            end
            ST_PROT: begin
                if (ctl_q.cnt == CW'(0)) begin
                    ctl_d.st = ST_IDLE;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - CW'(1);
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st       <= ST_IDLE;
            ctl_q.is_erase <= 1'b0;
            ctl_q.wdata    <= '1;
            ctl_q.store    <= '1;
            ctl_q.cnt      <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign start_o  = accept;
    assign busy_o   = (ctl_q.st != ST_IDLE);
    assign run_o    = (ctl_q.st == ST_PROG) || (ctl_q.st == ST_ERASE) || (ctl_q.st == ST_PROT);
    assign failed_o = (ctl_q.st == ST_FAIL);
    assign poll_o   = ctl_q.is_erase ? 1'b0 : ~ctl_q.wdata[DW-1];
    assign store_o  = ctl_q.store;

    a_r3_prog_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_PROG && timer_done && !pulse_over)
        |=> (ctl_q.store == ($past(ctl_q.store) & $past(ctl_q.wdata))));

    a_r4_erase_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_ERASE && timer_done && !pulse_over) |=> (ctl_q.store == '1));

    a_r7_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_PROT) |-> (ctl_q.cnt < CW'(MAXW)));

    a_r8_prot_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_PROT) |=> $stable(ctl_q.store));

    a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_FAIL && !cmd_valid) |=> (ctl_q.st == ST_FAIL && $stable(ctl_q.store)));

    a_r10_busy_ignores_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && cmd_valid) |=> ($stable(ctl_q.wdata) && $stable(ctl_q.is_erase)));

endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic run_i,
    input  logic rd_i,
    output logic tog_o
);

    logic tog_d, tog_q;

    always_comb begin
        tog_d = tog_q;
        if (start_i) begin
            tog_d = 1'b0;
        end else if (run_i && rd_i) begin
            tog_d = ~tog_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_d;
    end

    assign tog_o = tog_q;

    a_r5_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !tog_q);

    a_r5_flip_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && rd_i && !start_i) |=> (tog_q != $past(tog_q)));

    a_r9_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !start_i) |=> $stable(tog_q));

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
    parameter int unsigned DW           = 8,
    parameter int unsigned PROT_PGM_CYC = 8,
    parameter int unsigned PROT_ERS_CYC = 400
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_erase,
    input  logic [DW-1:0] cmd_data,
    input  logic          sect_prot,
    input  logic          timer_done,
    input  logic          pulse_over,
    input  logic          rd_strobe,
    output logic [DW-1:0] rd_data
);

    localparam int unsigned POLL_B = DW - 1;
    localparam int unsigned TOG_B  = DW - 2;
    localparam int unsigned FAIL_B = DW - 3;

    logic          start, busy, run, failed, poll, tog;
    logic [DW-1:0] store;

    fsg_op_ctrl #(
        .DW          (DW),
        .PROT_PGM_CYC(PROT_PGM_CYC),
        .PROT_ERS_CYC(PROT_ERS_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_erase (cmd_erase),
        .cmd_data  (cmd_data),
        .sect_prot (sect_prot),
        .timer_done(timer_done),
        .pulse_over(pulse_over),
        .start_o   (start),
        .busy_o    (busy),
        .run_o     (run),
        .failed_o  (failed),
        .poll_o    (poll),
        .store_o   (store)
    );

    fsg_toggle u_tog (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start),
        .run_i  (run),
        .rd_i   (rd_strobe),
        .tog_o  (tog)
    );

    always_comb begin
        rd_data = store;
        if (busy) begin
            rd_data[POLL_B] = poll;
            rd_data[TOG_B]  = tog;
            rd_data[FAIL_B] = failed;
        end
    end

    a_r6_low_bits_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(start)) |-> $stable(rd_data[FAIL_B-1:0]));

    a_r9_fail_flag_only_failed: assert property (@(posedge clk) disable iff (!rst_n)
        (run) |-> !rd_data[FAIL_B]);

endmodule

// File: tb/flash_status_gen_tb.sv
module flash_status_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PGM_W      = 8;
    localparam int ERS_W      = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0, cmd_erase = 1'b0, sect_prot = 1'b0;
    logic       timer_done = 1'b0, pulse_over = 1'b0, rd_strobe = 1'b0;
    logic [7:0] cmd_data = 8'h00;
    logic [7:0] rd_data;

    int   vecs = 0, fails = 0;
    bit   done = 1'b0;
    logic [7:0] mdl;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_status_gen #(.DW(8), .PROT_PGM_CYC(PGM_W), .PROT_ERS_CYC(ERS_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_erase(cmd_erase),
        .cmd_data(cmd_data), .sect_prot(sect_prot), .timer_done(timer_done),
        .pulse_over(pulse_over), .rd_strobe(rd_strobe), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] stat(input logic p, input logic t, input logic f);
        return {p, t, f, mdl[4:0]};
    endfunction

    task automatic do_cmd(input logic er, input logic [7:0] d, input logic pr);
        cmd_valid = 1'b1; cmd_erase = er; cmd_data = d; sect_prot = pr;
        @(negedge clk);
        cmd_valid = 1'b0; sect_prot = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] exp);
        rd_strobe = 1'b1;
        #1;
        chk(req, rd_data, exp);
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic finish_op();
        timer_done = 1'b1;
        @(negedge clk);
        timer_done = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d2;
        logic       et;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mdl = 8'hFF;
        chk("R1 reset", rd_data, 8'hFF);
        rd_chk("R5 idle read", mdl);
        chk("R5 idle after read", rd_data, mdl);

        // Sweep every program byte: erase, program, then a second program (R2, R3, R4, R5)
        for (int d = 0; d < 256; d++) begin
            do_cmd(1'b1, 8'h00, 1'b0);
            rd_chk("R4 erase poll", stat(1'b0, 1'b0, 1'b0));
            rd_chk("R5 erase toggle", stat(1'b0, 1'b1, 1'b0));
            finish_op();
            mdl = 8'hFF;
            chk("R4 erase done", rd_data, mdl);
            do_cmd(1'b0, 8'(d), 1'b0);
            rd_chk("R2 prog poll", stat(~d[7], 1'b0, 1'b0));
            rd_chk("R5 prog toggle", stat(~d[7], 1'b1, 1'b0));
            rd_chk("R6 prog low bits", stat(~d[7], 1'b0, 1'b0));
            finish_op();
            mdl = mdl & 8'(d);
            chk("R3 prog done", rd_data, mdl);
            d2 = {d[3:0], d[7:4]} ^ 8'h96;
            do_cmd(1'b0, d2, 1'b0);
            rd_chk("R6 reprog low bits", stat(~d2[7], 1'b0, 1'b0));
            finish_op();
            mdl = mdl & d2;
            chk("R3 AND merge", rd_data, mdl);
        end

        // R10: command during a running program is ignored
        do_cmd(1'b0, 8'h3C, 1'b0);
        do_cmd(1'b1, 8'h00, 1'b1);
        rd_chk("R10 cmd ignored", stat(1'b1, 1'b0, 1'b0));
        finish_op();
        mdl = mdl & 8'h3C;
        chk("R10 prog result", rd_data, mdl);

        // R7: protected program window
        do_cmd(1'b1, 8'h00, 1'b0); finish_op(); mdl = 8'hFF;
        do_cmd(1'b0, 8'h80, 1'b1);
        timer_done = 1'b1;
        et = 1'b0;
        for (int j = 0; j < PGM_W; j++) begin
            rd_strobe = (j == 1);
            #1;
            chk("R7 prot prog window", rd_data, stat(1'b0, et, 1'b0));
            @(negedge clk);
            if (j == 1) et = 1'b1;
        end
        rd_strobe = 1'b0; timer_done = 1'b0;
        chk("R7 prot prog end", rd_data, mdl);

        // R8: protected erase window
        do_cmd(1'b0, 8'h35, 1'b0); finish_op(); mdl = mdl & 8'h35;
        chk("R3 setup", rd_data, 8'h35);
        do_cmd(1'b1, 8'h00, 1'b1);
        timer_done = 1'b1;
        et = 1'b0;
        for (int j = 0; j < ERS_W; j++) begin
            rd_strobe = (j == 1);
            #1;
            chk("R8 prot erase window", rd_data, stat(1'b0, et, 1'b0));
            @(negedge clk);
            if (j == 1) et = 1'b1;
        end
        rd_strobe = 1'b0; timer_done = 1'b0;
        chk("R8 prot erase end", rd_data, mdl);

        // R9: failure during erase
        do_cmd(1'b1, 8'h00, 1'b0);
        pulse_over = 1'b1; @(negedge clk); pulse_over = 1'b0;
        rd_chk("R9 fail flag", stat(1'b0, 1'b0, 1'b1));
        rd_chk("R9 toggle frozen", stat(1'b0, 1'b0, 1'b1));
        finish_op();
        chk("R9 done ignored", rd_data, stat(1'b0, 1'b0, 1'b1));
        do_cmd(1'b0, 8'hF0, 1'b0);
        chk("R9 new cmd leaves fail", rd_data, stat(1'b0, 1'b0, 1'b0));
        finish_op();
        mdl = mdl & 8'hF0;
        chk("R9 prog after fail", rd_data, mdl);

        // R9: pulse_over beats timer_done in a program
        do_cmd(1'b0, 8'h0F, 1'b0);
        pulse_over = 1'b1; timer_done = 1'b1;
        @(negedge clk);
        pulse_over = 1'b0; timer_done = 1'b0;
        chk("R9 fail priority", rd_data, stat(1'b1, 1'b0, 1'b1));
        do_cmd(1'b1, 8'h00, 1'b0); finish_op(); mdl = 8'hFF;
        chk("R9 erase after fail", rd_data, mdl);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule